// File: doc/BRIEF.md
# Periodic Acquisition Trigger Synchronizer

This block paces repeated acquisitions for time-resolved measurements. A slow seconds-rate tick drives an interval timer that raises a ready flag once every chosen power-of-two number of seconds. A fast phase counter, clocked by the acquisition clock, marks the start of each modulation period. The run controller gets a start pulse only when a modulation-period mark arrives while the ready flag is up. As a result, each acquisition begins on the modulation phase, at most once per interval.

The unit stays idle until its enable switch turns on. A one-shot arming pulse then clears the interval timer and the ready flag. When that pulse ends, the unit is enabled. The phase counter runs freely from reset, and its period mark is always exported as a reset pulse for an external signal generator. The enable switch only decides whether the mark may request an acquisition. Everything runs on one clock, and the seconds tick is a one-cycle strobe in that clock domain.

Top module: `acq_sync_trigger`

## Requirements
- R1: While `rst_n` is low at a clock edge, every output is 0 after that edge.
- R2: If `sync_en` is first sampled high at edge k, then `syst_ready` is 1 for exactly the one cycle after edge k+1, and `syst_enable` is 1 from edge k+2 onward.
- R3: The `syst_ready` pulse clears the interval tick count and `acq_ready`, so after arming `acq_ready` is 0.
- R4: With `syst_enable` high, `acq_ready` is set at the edge that samples the 2^N-th `sec_tick` since arming, and again every 2^N ticks after that. Here N = `intv_sel` + 1, where `intv_sel` is an unsigned 3-bit value 0..7.
- R5: A phase counter starts at 0 when reset releases and advances once per clock. `gen_reset` is a one-cycle pulse after each edge at which the counter's low M bits are all ones. Here M = `mod_sel` + 5, where `mod_sel` is an unsigned 3-bit value 0..7.
- R6: `go_req` is the `gen_reset` pulse gated by `syst_enable` as it stood before that edge. It is never more than one cycle long.
- R7: `run_trigger` is a one-cycle pulse after each edge that sees `go_req`, `acq_ready` and `syst_enable` all high. `acq_ready` clears at that same edge, unless a new interval completes on that edge.
- R8: A `go_req` pulse while `acq_ready` is low is dropped. It gives no trigger, and it is not held over for later.
- R9: An edge that sees the sampled switch low clears `syst_enable` and `acq_ready`, and holds the interval count at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Acquisition-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sec_tick | input | 1 | One-cycle strobe, once per second |
| intv_sel | input | 3 | Interval choice, 2^(intv_sel+1) ticks |
| mod_sel | input | 3 | Modulation period choice, 2^(mod_sel+5) clocks |
| sync_en | input | 1 | Synchronizer enable switch |
| acq_ready | output | 1 | Interval elapsed, waiting for phase |
| go_req | output | 1 | Enabled modulation-phase request pulse |
| syst_ready | output | 1 | One-shot arming pulse |
| syst_enable | output | 1 | Unit armed and enabled |
| gen_reset | output | 1 | Modulation-period mark for the generator |
| run_trigger | output | 1 | Start pulse to the run controller |

## Verification
The bench tries three pairings of interval and modulation period. In the first, the interval is much shorter than the modulation period, so triggers follow the phase mark. In the second, the two are comparable, so the trigger times show whether the ready flag waits for the next mark. In the third, the interval is far longer than the period, so most requests must be dropped. A switch-off and re-arm sequence checks the arming pulse timing and confirms that the pending ready flag and interval count are discarded. A behavioural model compares every output on every clock.

// File: rtl/acqsync_pkg.sv
// Shared helpers for the acquisition trigger synchronizer.
// Assumes counters no wider than 16 bits.
package acqsync_pkg;
    localparam int unsigned MAXW = 16;

    // True when the low 'bits' bits of cnt are all ones (a tap is about to fall).
    function automatic logic low_bits_full(logic [MAXW-1:0] cnt, int unsigned bits);
        logic [MAXW-1:0] mask;
        mask = (bits >= MAXW) ? {MAXW{1'b1}} : ((MAXW'(1) << bits) - MAXW'(1));
        return &(cnt | ~mask);
    endfunction
endpackage

// File: rtl/arm_ctrl.sv
// Arming control: samples the enable switch, makes a one-cycle arming
// pulse after it turns on, and raises the enable flag as the pulse ends.
// Assumes the switch is already synchronous to clk.
module arm_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_en,
    output logic en_live,
    output logic syst_ready,
    output logic syst_enable
);
    logic en_prev;

    // Sample the switch and its previous value, form the one-shot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_live    <= 1'b0;
            en_prev    <= 1'b0;
            syst_ready <= 1'b0;
        end else begin
            en_live    <= sync_en;
            en_prev    <= en_live;
            syst_ready <= en_live & ~en_prev;
        end
    end

    // Enable flag: set when the arming pulse ends, cleared when switched off.
    always_ff @(posedge clk) begin
        if (!rst_n)           syst_enable <= 1'b0;
        else if (!en_live)    syst_enable <= 1'b0;
        else if (syst_ready)  syst_enable <= 1'b1;
    end

    assert_ready_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        syst_ready |=> !syst_ready);
    assert_enable_after_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(syst_enable) |-> $past(syst_ready));
    assert_off_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !en_live |=> !syst_enable);
endmodule

// File: rtl/intv_timer.sv
// Interval timer: counts seconds ticks while enabled and flags the tick
// that completes a 2^(sel+1) interval. Assumes CNT_W >= 2^SEL_W.
module intv_timer #(
    parameter int unsigned SEL_W = 3,
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             enable,
    input  logic             tick,
    input  logic [SEL_W-1:0] sel,
    output logic             hit
);
    import acqsync_pkg::*;
    logic [CNT_W-1:0] cnt;
    int unsigned      span;

    // Number of counter bits making up the chosen interval.
    always_comb span = int'(sel) + 1;

    // Interval completes on the tick that wraps the low span bits.
    always_comb hit = enable & ~clear & tick & low_bits_full(MAXW'(cnt), span);

    // Tick counter, held at zero unless enabled and not being cleared.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt <= '0;
        else if (clear || !enable) cnt <= '0;
        else if (tick)           cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/mod_timer.sv
// Modulation phase counter: free-running at the acquisition clock; emits a
// registered one-cycle mark every 2^(sel+MIN_N) clocks. Assumes MIN_N >= 1.
module mod_timer #(
    parameter int unsigned SEL_W = 3,
    parameter int unsigned MIN_N = 5,
    parameter int unsigned CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             mark
);
    import acqsync_pkg::*;
    logic [CNT_W-1:0] phase;
    logic             wrap;

    // Period ends when the low sel+MIN_N bits are all ones.
    always_comb wrap = low_bits_full(MAXW'(phase), int'(sel) + MIN_N);

    // Advance the phase and register the period mark.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= '0;
            mark  <= 1'b0;
        end else begin
            phase <= phase + CNT_W'(1);
            mark  <= wrap;
        end
    end

    assert_mark_single_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mark |=> !mark);
endmodule

// File: rtl/acq_sync_trigger.sv
// Top of the periodic acquisition trigger synchronizer. Combines the arming
// control, interval timer and modulation timer; issues a run trigger when a
// phase request meets a pending ready flag. Single clock domain.
module acq_sync_trigger #(
    parameter int unsigned SEL_W  = 3,
    parameter int unsigned INTV_W = 8,
    parameter int unsigned MOD_MIN = 5,
    parameter int unsigned MOD_W  = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sec_tick,
    input  logic [SEL_W-1:0] intv_sel,
    input  logic [SEL_W-1:0] mod_sel,
    input  logic             sync_en,
    output logic             acq_ready,
    output logic             go_req,
    output logic             syst_ready,
    output logic             syst_enable,
    output logic             gen_reset,
    output logic             run_trigger
);
    logic en_live;
    logic intv_hit;
    logic fire;

    arm_ctrl u_arm (
        .clk(clk), .rst_n(rst_n), .sync_en(sync_en),
        .en_live(en_live), .syst_ready(syst_ready), .syst_enable(syst_enable)
    );

    intv_timer #(.SEL_W(SEL_W), .CNT_W(INTV_W)) u_intv (
        .clk(clk), .rst_n(rst_n), .clear(syst_ready), .enable(syst_enable),
        .tick(sec_tick), .sel(intv_sel), .hit(intv_hit)
    );

    mod_timer #(.SEL_W(SEL_W), .MIN_N(MOD_MIN), .CNT_W(MOD_W)) u_mod (
        .clk(clk), .rst_n(rst_n), .sel(mod_sel), .mark(gen_reset)
    );

    // Coincidence of phase request and pending interval.
    always_comb fire = go_req & acq_ready & syst_enable;

    // Phase request, ready flag and trigger pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go_req      <= 1'b0;
            acq_ready   <= 1'b0;
            run_trigger <= 1'b0;
        end else begin
            go_req      <= u_mod.wrap & syst_enable;
            run_trigger <= fire;
            if (!en_live || syst_ready) acq_ready <= 1'b0;
            else if (intv_hit)          acq_ready <= 1'b1;
            else if (fire)              acq_ready <= 1'b0;
        end
    end

    assert_trigger_coincide_R7: assert property (@(posedge clk) disable iff (!rst_n)
        run_trigger |-> $past(go_req && acq_ready));
    assert_no_trigger_unready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (go_req && !acq_ready) |=> !run_trigger);
    assert_arm_clears_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
        syst_ready |=> !acq_ready);
    assert_go_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        go_req |=> !go_req);
endmodule

// File: tb/sim_acq_sync_trigger.sv
module sim_acq_sync_trigger;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sec_tick = 1'b0;
    logic [2:0] intv_sel = 3'd0;
    logic [2:0] mod_sel = 3'd0;
    logic sync_en = 1'b0;
    logic acq_ready, go_req, syst_ready, syst_enable, gen_reset, run_trigger;

    int total = 0;
    int bad = 0;
    bit done = 0;
    localparam int TP = 3;
    int tdiv = 0;

    acq_sync_trigger u0 (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .intv_sel(intv_sel),
        .mod_sel(mod_sel), .sync_en(sync_en), .acq_ready(acq_ready), .go_req(go_req),
        .syst_ready(syst_ready), .syst_enable(syst_enable), .gen_reset(gen_reset),
        .run_trigger(run_trigger)
    );

    always #2 clk = ~clk;

    // Seconds strobe every TP clocks, driven away from the active edge.
    always @(negedge clk) begin
        tdiv = (tdiv == TP - 1) ? 0 : tdiv + 1;
        sec_tick <= (tdiv == 0);
    end

    // Behavioural reference state.
    int m_sw, m_swp, m_sr, m_se, m_ar, m_gr, m_gen, m_trig;
    int ticks, phase;
    int n_sw, n_swp, n_sr, n_se, n_ar, n_gr, n_gen, n_trig;
    int per, span, fire, ihit;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sw = 0; m_swp = 0; m_sr = 0; m_se = 0; m_ar = 0;
            m_gr = 0; m_gen = 0; m_trig = 0; ticks = 0; phase = 0;
        end else begin
            per  = 1 << (int'(mod_sel) + 5);
            span = 1 << (int'(intv_sel) + 1);
            n_sw = sync_en; n_swp = m_sw; n_sr = (m_sw && !m_swp);
            n_se = !m_sw ? 0 : (m_sr ? 1 : m_se);
            n_gen = ((phase % per) == per - 1);
            n_gr  = n_gen && m_se;
            fire  = m_gr && m_ar && m_se;
            n_trig = fire;
            ihit  = m_se && !m_sr && sec_tick && (((ticks + 1) % span) == 0);
            if (!m_sw || m_sr) n_ar = 0;
            else if (ihit)     n_ar = 1;
            else if (fire)     n_ar = 0;
            else               n_ar = m_ar;
            if (!m_se || m_sr) ticks = 0;
            else if (sec_tick) ticks = ticks + 1;
            phase = phase + 1;
            m_sw = n_sw; m_swp = n_swp; m_sr = n_sr; m_se = n_se; m_ar = n_ar;
            m_gr = n_gr; m_gen = n_gen; m_trig = n_trig;
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // Compare every output with the model on each falling edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check("R2", "syst_ready",  syst_ready,  m_sr);
            check("R2", "syst_enable", syst_enable, m_se);
            check("R4", "acq_ready",   acq_ready,   m_ar);
            check("R6", "go_req",      go_req,      m_gr);
            check("R5", "gen_reset",   gen_reset,   m_gen);
            check("R7", "run_trigger", run_trigger, m_trig);
        end
    end

    int trig_cnt = 0;
    int go_cnt = 0;
    always @(negedge clk) begin
        if (run_trigger) trig_cnt++;
        if (go_req) go_cnt++;
    end

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run();
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    // Watchdog.
    initial begin
        #(4 * 150000);
        bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        cycles(3);
        // R1: outputs idle under reset.
        check("R1", "reset outputs",
              {acq_ready, go_req, syst_ready, syst_enable, gen_reset, run_trigger}, 0);
        rst_n = 1'b1;

        // Short interval, long phase: triggers follow the phase mark (R4, R7).
        intv_sel = 3'd0; mod_sel = 3'd0;
        sync_en = 1'b1;
        cycles(1);                 // edge k samples switch
        check("R2", "no pulse yet", syst_ready, 0);
        cycles(1);
        check("R2", "arming pulse", syst_ready, 1);
        cycles(1);
        check("R2", "pulse ended", syst_ready, 0);
        check("R2", "enabled", syst_enable, 1);
        check("R3", "ready clear after arm", acq_ready, 0);
        trig_cnt = 0;
        cycles(640);
        check("R7", "triggers in short interval run", trig_cnt, 20);

        // Comparable interval and period.
        intv_sel = 3'd3; mod_sel = 3'd1;
        cycles(1500);
        check("R7", "triggers seen", int'(trig_cnt > 20), 1);

        // Long interval, short period: most requests dropped (R8).
        intv_sel = 3'd7; mod_sel = 3'd0;
        sync_en = 1'b0;
        cycles(4);
        // R9: switched off clears flags.
        check("R9", "off enable", syst_enable, 0);
        check("R9", "off ready", acq_ready, 0);
        sync_en = 1'b1;
        cycles(3);
        check("R3", "re-armed ready clear", acq_ready, 0);
        trig_cnt = 0; go_cnt = 0;
        cycles(3200);
        check("R8", "dropped requests", int'(go_cnt > trig_cnt + 50), 1);
        check("R8", "one trigger per interval", int'(trig_cnt >= 3 && trig_cnt <= 5), 1);

        // Longest modulation period.
        mod_sel = 3'd7; intv_sel = 3'd1;
        cycles(9000);

        sync_en = 1'b0;
        cycles(5);
        check("R9", "final off", {syst_enable, acq_ready, go_req, run_trigger}, 0);
        finish_run();
    end
endmodule